// File: doc/BRIEF.md
# NAND Page Sector Sequencer

This block runs one raw NAND page transfer, in either direction, as a chain of fixed-size sectors. Every sector is a 512-byte data area, then an 8-byte free-data area, then a parity area that fills the rest of the selected spare size. The block counts the bytes inside the current sector and decides which area each byte belongs to. It also counts finished sectors and returns to idle on its own once the programmed number of sectors has moved. Software moves the payload through a programmed-I/O port, one byte or one 32-bit little-endian word per access, gated by a ready flag. On the flash side the block presents a plain byte stream. Pin timing, error-correction arithmetic and DMA belong to other blocks.

In auto-format mode the free-data bytes never cross the PIO port. On a write they are taken from a small store with two 32-bit words per sector, and the parity area is filled with 0xFF placeholders for a downstream encoder. On a read the free-data bytes are captured into that same store and the parity bytes are dropped. In raw mode every byte of every area passes through the PIO port in stream order. Setting the sector count to all-ones gives a free-running transfer that only a soft reset ends.

Top module: `nand_sector_seq`

## Requirements
- R1: After `rst`, or in the cycle after a `soft_rst` pulse, `busy`, `pio_ready`, `fl_rx_ready` and `fl_tx_valid` are 0 and `sect_cnt` is 0. A transfer in progress is abandoned and any bytes buffered for PIO are discarded.
- R2: A `start` pulse in idle with a nonzero `cfg_sectors` latches the configuration and raises `busy` on the next clock edge. A `start` with `cfg_sectors` = 0 has no effect.
- R3: A sector is 512 data bytes, then 8 free-data bytes, then (S - 8) parity bytes. S is 16, 26, 27 or 28 for `cfg_spare_code` 0, 1, 2 or 3, so a sector is 512 + S bytes long.
- R4: `cfg_page_code` 0, 1 and 2 give pages of 1, 4 and 8 sectors; code 3 acts as 8. A sector count larger than the page is clamped to the page's sector count.
- R5: `sect_cnt` rises by one after the last byte of each sector. When it reaches the target, `busy` falls and `done` is high for exactly one cycle. `sect_cnt` then holds until the next accepted start or reset.
- R6: `cfg_byte_mode`=1 moves one byte per PIO access in bits 7:0; on writes bits 31:8 are ignored, and on reads they are 0. `cfg_byte_mode`=0 moves 4 bytes per access, with the first stream byte in bits 7:0. An access happens only in a cycle where `pio_ready` is 1 and `pio_wr` or `pio_rd` is 1.
- R7: On a word-mode read whose stream length is not a multiple of 4, the final partial word is offered after `busy` falls, with its unused upper bytes at 0.
- R8: An auto-format write takes free-data byte j (0..7) of sector n from store word 2n + j/4, byte lane j%4 (little-endian), and sends 0xFF for every parity byte. The PIO port supplies only data-area bytes.
- R9: An auto-format read writes free-data bytes 0..3 and 4..7 of sector n, little-endian, into store words 2n and 2n+1. Neither free-data nor parity bytes appear on the PIO port.
- R10: With auto-format off, every data, free-data and parity byte of every sector is sent or received through the PIO port in stream order.
- R11: A `cfg_sectors` of 15 (all ones) starts a transfer that never completes by itself and never pulses `done`. `sect_cnt` still counts finished sectors and saturates at 15.
- R12: A host write to the free-data store is carried out only while idle. A write attempted while `busy` leaves the store unchanged. A host read returns the addressed word one cycle after `fdm_addr` is presented.
- R13: `fl_rx_ready` is 1 only during a read transfer that can accept a byte. A flash byte is consumed in a cycle where both `fl_rx_valid` and `fl_rx_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Abort the transfer and flush the PIO buffers |
| start | input | 1 | Start-data strobe |
| cfg_page_code | input | 2 | Page size code |
| cfg_spare_code | input | 2 | Per-sector spare size code |
| cfg_write | input | 1 | 1 = write to flash, 0 = read from flash |
| cfg_sectors | input | 4 | Sectors to transfer; 15 = free-running |
| cfg_auto_fmt | input | 1 | Auto-format mode |
| cfg_byte_mode | input | 1 | 1 = byte PIO accesses, 0 = word PIO accesses |
| pio_ready | output | 1 | PIO access may take place |
| pio_wr | input | 1 | PIO write strobe |
| pio_wdata | input | 32 | PIO write data |
| pio_rd | input | 1 | PIO read strobe |
| pio_rdata | output | 32 | PIO read data |
| fl_tx_valid | output | 1 | Byte to flash valid |
| fl_tx_byte | output | 8 | Byte to flash |
| fl_rx_ready | output | 1 | Ready to take a byte from flash |
| fl_rx_valid | input | 1 | Byte from flash valid |
| fl_rx_byte | input | 8 | Byte from flash |
| fdm_we | input | 1 | Host free-data store write |
| fdm_addr | input | 5 | Store word address (2 x sector + half) |
| fdm_wdata | input | 32 | Store write data |
| fdm_rdata | output | 32 | Store read data, one cycle after the address |
| busy | output | 1 | Transfer in progress |
| sect_cnt | output | 4 | Completed-sector counter |
| done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
The sequencer is driven with five patterns:
- A raw byte-mode write with a sector count above the page size. It separates correct area lengths and count clamping from an overrun or an early stop, and byte-lane masking from leaking upper bits.
- A two-sector auto-format word write with a 26-byte spare. It shows whether the free-data bytes come from the store in little-endian order, whether parity bytes become 0xFF, and whether the sector index advances.
- A raw word-mode read with a 27-byte spare. Its 539-byte stream leaves a 3-byte tail, which exposes wrong word packing or a lost final partial word.
- An auto-format byte read. It tells capture into the store apart from leakage of free-data or parity bytes onto the PIO port.
- A free-running read ended by a soft reset. It separates correct saturation and abort from spurious completion, and it shows that a store write attempted mid-transfer is blocked.

// File: rtl/nss_pkg.sv
package nss_pkg;
  localparam int SPARE_W = 6;

  typedef enum logic [1:0] {
    AREA_DATA   = 2'd0,
    AREA_FDM    = 2'd1,
    AREA_PARITY = 2'd2
  } area_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } state_e;

  // Spare bytes per sector for each spare size code.
  function automatic logic [SPARE_W-1:0] spare_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd26;
      2'd2:    return 6'd27;
      default: return 6'd28;
    endcase
  endfunction

  // Sectors per page for each page size code (code 3 behaves as 8).
  function automatic int unsigned page_sectors(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/nss_layout.sv
module nss_layout import nss_pkg::*; #(
  parameter int DATA_BYTES = 512,
  parameter int FDM_BYTES  = 8,
  parameter int CNT_W      = 4,
  localparam int OFS_W     = $clog2(DATA_BYTES + (1 << SPARE_W)),
  localparam int FIDX_W    = $clog2(FDM_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               step,
  input  logic [SPARE_W-1:0] spare,
  output area_e              area,
  output logic [FIDX_W-1:0]  fdm_idx,
  output logic               sect_last,
  output logic [CNT_W-1:0]   sect_idx,
  output logic [CNT_W-1:0]   done_cnt
);
  localparam logic [OFS_W-1:0] DATA_END = OFS_W'(DATA_BYTES);
  localparam logic [OFS_W-1:0] FDM_END  = OFS_W'(DATA_BYTES + FDM_BYTES);

  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] last_ofs;

  assign last_ofs  = DATA_END + OFS_W'(spare) - OFS_W'(1);
  assign sect_last = (ofs == last_ofs);
  assign fdm_idx   = FIDX_W'(ofs - DATA_END);

  always_comb begin
    if (ofs < DATA_END)     area = AREA_DATA;
    else if (ofs < FDM_END) area = AREA_FDM;
    else                    area = AREA_PARITY;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ofs      <= '0;
      sect_idx <= '0;
      done_cnt <= '0;
    end else if (step) begin
      if (sect_last) begin
        ofs      <= '0;
        sect_idx <= sect_idx + CNT_W'(1);
        if (done_cnt != '1) done_cnt <= done_cnt + CNT_W'(1);
      end else begin
        ofs <= ofs + OFS_W'(1);
      end
    end
  end

  // The byte offset never runs past the end of the sector.
  assert_ofs_in_sector_R3: assert property (@(posedge clk) disable iff (rst)
    ofs <= last_ofs);

  // A full counter stays full until cleared.
  assert_cnt_saturates_R11: assert property (@(posedge clk) disable iff (rst)
    (done_cnt == '1 && !clr) |=> done_cnt == '1);
endmodule

// File: rtl/nss_pio.sv
module nss_pio #(
  parameter int WORD_BYTES = 4,
  localparam int DW        = 8 * WORD_BYTES,
  localparam int BC_W      = $clog2(WORD_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          byte_mode,
  input  logic          dir_write,
  input  logic          active,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic          ready,
  output logic [DW-1:0] host_rdata,
  input  logic          take,
  output logic          wr_has_byte,
  output logic [7:0]    wr_byte,
  input  logic          put,
  input  logic [7:0]    put_byte,
  output logic          rd_space
);
  logic [DW-1:0]   wbuf, rbuf;
  logic [BC_W-1:0] wcnt, rcnt, need;
  logic            wr_acc, rd_acc;

  assign need        = byte_mode ? BC_W'(1) : BC_W'(WORD_BYTES);
  assign ready       = dir_write ? (active && wcnt == '0)
                                 : (rcnt != '0 && (rcnt == need || !active));
  assign wr_acc      = host_wr && ready && dir_write;
  assign rd_acc      = host_rd && ready && !dir_write;
  assign wr_has_byte = (wcnt != '0);
  assign wr_byte     = wbuf[7:0];
  assign rd_space    = (rcnt < need);
  assign host_rdata  = rbuf;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wbuf <= '0;
      wcnt <= '0;
      rbuf <= '0;
      rcnt <= '0;
    end else begin
      if (wr_acc) begin
        wbuf <= host_wdata;
        wcnt <= need;
      end else if (take) begin
        wbuf <= wbuf >> 8;
        wcnt <= wcnt - BC_W'(1);
      end
      if (rd_acc) begin
        rbuf <= '0;
        rcnt <= '0;
      end else if (put) begin
        for (int i = 0; i < WORD_BYTES; i++)
          if (rcnt == BC_W'(i)) rbuf[8*i +: 8] <= put_byte;
        rcnt <= rcnt + BC_W'(1);
      end
    end
  end

  assert_take_has_byte_R6: assert property (@(posedge clk) disable iff (rst)
    take |-> wcnt != '0);

  assert_put_has_space_R13: assert property (@(posedge clk) disable iff (rst)
    put |-> rcnt < need);

  assert_read_empties_R6: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> rcnt == '0);
endmodule

// File: rtl/nss_fdm_store.sv
module nss_fdm_store #(
  parameter int WORD_W = 32,
  parameter int SECTS  = 16,
  localparam int AW    = $clog2(2 * SECTS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     int_raddr,
  output logic [WORD_W-1:0] int_rdata,
  input  logic [AW-1:0]     host_raddr,
  output logic [WORD_W-1:0] host_rdata
);
  // Two words per sector; single write port, distributed-RAM friendly.
  logic [WORD_W-1:0] mem [2*SECTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    host_rdata <= mem[host_raddr];
  end

  assign int_rdata = mem[int_raddr];
endmodule

// File: rtl/nand_sector_seq.sv
module nand_sector_seq import nss_pkg::*; #(
  parameter int DATA_BYTES = 512,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 4,
  localparam int FDM_BYTES = 2 * WORD_BYTES,
  localparam int DW        = 8 * WORD_BYTES,
  localparam int FA_W      = CNT_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_rst,
  input  logic            start,
  input  logic [1:0]      cfg_page_code,
  input  logic [1:0]      cfg_spare_code,
  input  logic            cfg_write,
  input  logic [CNT_W-1:0] cfg_sectors,
  input  logic            cfg_auto_fmt,
  input  logic            cfg_byte_mode,
  output logic            pio_ready,
  input  logic            pio_wr,
  input  logic [DW-1:0]   pio_wdata,
  input  logic            pio_rd,
  output logic [DW-1:0]   pio_rdata,
  output logic            fl_tx_valid,
  output logic [7:0]      fl_tx_byte,
  output logic            fl_rx_ready,
  input  logic            fl_rx_valid,
  input  logic [7:0]      fl_rx_byte,
  input  logic            fdm_we,
  input  logic [FA_W-1:0] fdm_addr,
  input  logic [DW-1:0]   fdm_wdata,
  output logic [DW-1:0]   fdm_rdata,
  output logic            busy,
  output logic [CNT_W-1:0] sect_cnt,
  output logic            done
);
  localparam int WB_W   = $clog2(WORD_BYTES);
  localparam int FIDX_W = $clog2(FDM_BYTES);

  state_e             state;
  logic               l_write, l_auto, l_byte, l_cont;
  logic [SPARE_W-1:0] l_spare;
  logic [CNT_W-1:0]   l_target;
  logic [CNT_W-1:0]   pg_sect, clamp_sect;

  logic               start_ok, clr, active, fmt_area;
  logic               step_w, step_r, step, take, put, finish;
  logic               wr_has_byte, rd_space;
  logic [7:0]         wr_byte, fmt_byte, tx_byte_c;

  area_e              area;
  logic [FIDX_W-1:0]  fidx;
  logic               sect_last;
  logic [CNT_W-1:0]   sect_idx, done_cnt;

  logic [DW-9:0]      cap;
  logic               cap_byte, cap_we, host_we;
  logic               mem_we;
  logic [FA_W-1:0]    mem_waddr, int_raddr;
  logic [DW-1:0]      mem_wdata, int_rdata;

  // Start acceptance and target sector count (clamped to page size).
  assign pg_sect    = CNT_W'(page_sectors(cfg_page_code));
  assign clamp_sect = (cfg_sectors > pg_sect) ? pg_sect : cfg_sectors;
  assign start_ok   = (state == ST_IDLE) && start && !soft_rst && (cfg_sectors != '0);
  assign clr        = start_ok || soft_rst;
  assign active     = (state == ST_DATA);
  assign fmt_area   = l_auto && (area != AREA_DATA);

  // Byte stepping in each direction.
  assign step_w      = active && l_write && (fmt_area || wr_has_byte);
  assign fl_rx_ready = active && !l_write && (fmt_area || rd_space);
  assign step_r      = fl_rx_ready && fl_rx_valid;
  assign step        = step_w || step_r;
  assign take        = step_w && !fmt_area;
  assign put         = step_r && !fmt_area;
  assign finish      = step && sect_last && !l_cont && ((done_cnt + CNT_W'(1)) == l_target);

  // Free-data byte selection for auto-format writes.
  assign int_raddr = {sect_idx, fidx[WB_W]};
  assign fmt_byte  = int_rdata[8*fidx[WB_W-1:0] +: 8];
  assign tx_byte_c = !fmt_area ? wr_byte : ((area == AREA_FDM) ? fmt_byte : 8'hFF);

  // Free-data capture for auto-format reads: word written on its last lane.
  assign cap_byte  = step_r && l_auto && (area == AREA_FDM);
  assign cap_we    = cap_byte && (fidx[WB_W-1:0] == '1);
  assign host_we   = fdm_we && (state == ST_IDLE);
  assign mem_we    = cap_we || host_we;
  assign mem_waddr = cap_we ? {sect_idx, fidx[WB_W]} : fdm_addr;
  assign mem_wdata = cap_we ? {fl_rx_byte, cap} : fdm_wdata;

  always_ff @(posedge clk) begin
    if (rst) cap <= '0;
    else if (cap_byte && !cap_we)
      for (int i = 0; i < WORD_BYTES - 1; i++)
        if (fidx[WB_W-1:0] == WB_W'(i)) cap[8*i +: 8] <= fl_rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state       <= ST_IDLE;
      fl_tx_valid <= 1'b0;
      fl_tx_byte  <= 8'h00;
      done        <= 1'b0;
      l_write     <= 1'b0;
      l_auto      <= 1'b0;
      l_byte      <= 1'b0;
      l_cont      <= 1'b0;
      l_spare     <= '0;
      l_target    <= '0;
    end else begin
      fl_tx_valid <= step_w;
      fl_tx_byte  <= tx_byte_c;
      done        <= finish;
      if (start_ok) begin
        state    <= ST_DATA;
        l_write  <= cfg_write;
        l_auto   <= cfg_auto_fmt;
        l_byte   <= cfg_byte_mode;
        l_cont   <= (cfg_sectors == '1);
        l_spare  <= spare_bytes(cfg_spare_code);
        l_target <= clamp_sect;
      end else if (finish) begin
        state <= ST_IDLE;
      end
    end
  end

  assign busy     = active;
  assign sect_cnt = done_cnt;

  nss_layout #(
    .DATA_BYTES(DATA_BYTES), .FDM_BYTES(FDM_BYTES), .CNT_W(CNT_W)
  ) u_layout (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .spare(l_spare),
    .area(area), .fdm_idx(fidx), .sect_last(sect_last),
    .sect_idx(sect_idx), .done_cnt(done_cnt)
  );

  nss_pio #(.WORD_BYTES(WORD_BYTES)) u_pio (
    .clk(clk), .rst(rst), .flush(clr), .byte_mode(l_byte),
    .dir_write(l_write), .active(active),
    .host_wr(pio_wr), .host_wdata(pio_wdata), .host_rd(pio_rd),
    .ready(pio_ready), .host_rdata(pio_rdata),
    .take(take), .wr_has_byte(wr_has_byte), .wr_byte(wr_byte),
    .put(put), .put_byte(fl_rx_byte), .rd_space(rd_space)
  );

  nss_fdm_store #(.WORD_W(DW), .SECTS(1 << CNT_W)) u_fdm (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .int_raddr(int_raddr), .int_rdata(int_rdata),
    .host_raddr(fdm_addr), .host_rdata(fdm_rdata)
  );

  // Completion is only signalled at the target with the sequencer idle.
  assert_done_at_target_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && sect_cnt == l_target));

  // The counter moves by at most one per cycle during a transfer.
  assert_cnt_steps_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (sect_cnt == $past(sect_cnt) ||
                               sect_cnt == $past(sect_cnt) + CNT_W'(1)));

  // A transfer only begins on an accepted start.
  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && $past(cfg_sectors) != '0));

  // Soft reset leaves the block idle and cleared.
  assert_soft_abort_R1: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst) |-> (!busy && sect_cnt == '0 && !fl_tx_valid && !pio_ready));

  // Flash bytes only leave during a write transfer.
  assert_tx_in_write_R8: assert property (@(posedge clk) disable iff (rst)
    fl_tx_valid |-> $past(busy) && $past(l_write));
endmodule

// File: tb/tb_nand_sector_seq.sv
module tb_nand_sector_seq;
  logic        clk = 1'b0;
  logic        rst, soft_rst, start;
  logic [1:0]  cfg_page_code, cfg_spare_code;
  logic        cfg_write, cfg_auto_fmt, cfg_byte_mode;
  logic [3:0]  cfg_sectors;
  logic        pio_ready, pio_wr, pio_rd;
  logic [31:0] pio_wdata, pio_rdata;
  logic        fl_tx_valid, fl_rx_ready, fl_rx_valid;
  logic [7:0]  fl_tx_byte, fl_rx_byte;
  logic        fdm_we;
  logic [4:0]  fdm_addr;
  logic [31:0] fdm_wdata, fdm_rdata;
  logic        busy, done;
  logic [3:0]  sect_cnt;

  always #10 clk = ~clk;

  nand_sector_seq dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start),
    .cfg_page_code(cfg_page_code), .cfg_spare_code(cfg_spare_code),
    .cfg_write(cfg_write), .cfg_sectors(cfg_sectors),
    .cfg_auto_fmt(cfg_auto_fmt), .cfg_byte_mode(cfg_byte_mode),
    .pio_ready(pio_ready), .pio_wr(pio_wr), .pio_wdata(pio_wdata),
    .pio_rd(pio_rd), .pio_rdata(pio_rdata),
    .fl_tx_valid(fl_tx_valid), .fl_tx_byte(fl_tx_byte),
    .fl_rx_ready(fl_rx_ready), .fl_rx_valid(fl_rx_valid), .fl_rx_byte(fl_rx_byte),
    .fdm_we(fdm_we), .fdm_addr(fdm_addr), .fdm_wdata(fdm_wdata), .fdm_rdata(fdm_rdata),
    .busy(busy), .sect_cnt(sect_cnt), .done(done)
  );

  int checks = 0, failures = 0;
  int done_seen = 0;
  int rx_idx = 0;
  logic rx_clr = 1'b0;
  string cur_req = "R10";
  logic [7:0] exp_q[$];

  function automatic logic [7:0] rxb(int i);
    return 8'((i * 13 + 3) & 255);
  endfunction
  function automatic logic [7:0] dbyte(int s, int k);
    return 8'((s * 37 + k * 3 + 5) & 255);
  endfunction
  function automatic logic [31:0] fdm_val(int a);
    return 32'hC0DE0000 + 32'(a) * 32'h00110017;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Flash-side model: always offers the next pattern byte.
  assign fl_rx_valid = 1'b1;
  assign fl_rx_byte  = rxb(rx_idx);
  always @(posedge clk) begin
    if (rx_clr) rx_idx <= 0;
    else if (fl_rx_valid && fl_rx_ready) rx_idx <= rx_idx + 1;
    if (done) done_seen <= done_seen + 1;
  end

  // Scoreboard monitor: compare each flash-bound byte with the queue head.
  always @(negedge clk) begin
    if (fl_tx_valid) begin
      if (exp_q.size() == 0) chk({cur_req, " unexpected tx byte"}, {24'h0, fl_tx_byte}, 32'hFFFF_FFFF);
      else chk({cur_req, " tx byte"}, {24'h0, fl_tx_byte}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic put_word(logic [31:0] w);
    while (!pio_ready) @(negedge clk);
    pio_wr = 1'b1; pio_wdata = w;
    @(negedge clk);
    pio_wr = 1'b0;
  endtask

  task automatic get_word(output logic [31:0] w);
    while (!pio_ready) @(negedge clk);
    w = pio_rdata; pio_rd = 1'b1;
    @(negedge clk);
    pio_rd = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fdm_write(int a, logic [31:0] d);
    fdm_addr = 5'(a); fdm_wdata = d; fdm_we = 1'b1;
    @(negedge clk);
    fdm_we = 1'b0;
  endtask

  task automatic fdm_read(int a, output logic [31:0] d);
    fdm_addr = 5'(a);
    @(negedge clk);
    d = fdm_rdata;
  endtask

  task automatic go(logic [1:0] pg, logic [1:0] sp, logic wr, logic [3:0] ns, logic af, logic bm);
    cfg_page_code = pg; cfg_spare_code = sp; cfg_write = wr;
    cfg_sectors = ns; cfg_auto_fmt = af; cfg_byte_mode = bm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic clear_rx;
    rx_clr = 1'b1;
    @(negedge clk);
    rx_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, e;
    int base;
    rst = 1'b1; soft_rst = 1'b0; start = 1'b0; pio_wr = 1'b0; pio_rd = 1'b0;
    pio_wdata = '0; fdm_we = 1'b0; fdm_addr = '0; fdm_wdata = '0;
    cfg_page_code = '0; cfg_spare_code = '0; cfg_write = 1'b0; cfg_sectors = '0;
    cfg_auto_fmt = 1'b0; cfg_byte_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", {31'h0, busy}, 0);
    chk("R1 pio_ready", {31'h0, pio_ready}, 0);
    chk("R1 sect_cnt", {28'h0, sect_cnt}, 0);
    chk("R1 tx_valid", {31'h0, fl_tx_valid}, 0);
    chk("R1 rx_ready", {31'h0, fl_rx_ready}, 0);

    // R10/R6/R4: raw byte-mode write, count 3 on a 1-sector page, 16-byte spare
    cur_req = "R10";
    for (int i = 0; i < 528; i++) exp_q.push_back(8'((i * 7 + 1) & 255));
    base = done_seen;
    go(2'd0, 2'd0, 1'b1, 4'd3, 1'b0, 1'b1);
    chk("R2 busy after start", {31'h0, busy}, 1);
    chk("R13 rx_ready in write", {31'h0, fl_rx_ready}, 0);
    for (int i = 0; i < 528; i++) put_word({24'hABCDEF, 8'((i * 7 + 1) & 255)});
    wait_idle();
    chk("R4 clamped sect_cnt", {28'h0, sect_cnt}, 1);
    chk("R5 done pulses", 32'(done_seen - base), 1);
    chk("R3 all bytes sent", 32'(exp_q.size()), 0);

    // R8: auto-format word write, 4-sector page, 2 sectors, 26-byte spare
    for (int a = 0; a < 6; a++) fdm_write(a, fdm_val(a));
    cur_req = "R8";
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 512; k++) exp_q.push_back(dbyte(s, k));
      for (int j = 0; j < 8; j++) begin
        v = fdm_val(2 * s + j / 4);
        exp_q.push_back(v[8*(j%4) +: 8]);
      end
      for (int p = 0; p < 18; p++) exp_q.push_back(8'hFF);
    end
    base = done_seen;
    go(2'd1, 2'd1, 1'b1, 4'd2, 1'b1, 1'b0);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 128; w++)
        put_word({dbyte(s, 4*w+3), dbyte(s, 4*w+2), dbyte(s, 4*w+1), dbyte(s, 4*w)});
    wait_idle();
    chk("R5 sect_cnt after 2", {28'h0, sect_cnt}, 2);
    chk("R5 done pulses", 32'(done_seen - base), 1);
    chk("R8 all bytes sent", 32'(exp_q.size()), 0);

    // R2: zero sector count is ignored
    go(2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b1);
    chk("R2 zero count start ignored", {31'h0, busy}, 0);
    chk("R2 zero count rx_ready", {31'h0, fl_rx_ready}, 0);

    // R6/R7/R10: raw word read, 27-byte spare -> 539 bytes, 3-byte tail
    clear_rx();
    go(2'd0, 2'd2, 1'b0, 4'd1, 1'b0, 1'b0);
    for (int w = 0; w < 135; w++) begin
      get_word(v);
      for (int b = 0; b < 4; b++) e[8*b +: 8] = (4*w + b < 539) ? rxb(4*w + b) : 8'h00;
      if (w < 134) chk("R6 read word", v, e);
      else chk("R7 tail word", v, e);
    end
    wait_idle();
    chk("R7 nothing after tail", {31'h0, pio_ready}, 0);
    chk("R10 bytes consumed", 32'(rx_idx), 539);

    // R9: auto-format byte read, 28-byte spare
    clear_rx();
    go(2'd0, 2'd3, 1'b0, 4'd1, 1'b1, 1'b1);
    for (int i = 0; i < 512; i++) begin
      get_word(v);
      chk("R9 data byte", v, {24'h0, rxb(i)});
    end
    wait_idle();
    chk("R9 no fdm/parity on pio", {31'h0, pio_ready}, 0);
    chk("R3 bytes consumed", 32'(rx_idx), 540);
    fdm_read(0, v);
    chk("R9 fdm low captured", v, {rxb(515), rxb(514), rxb(513), rxb(512)});
    fdm_read(1, v);
    chk("R9 fdm high captured", v, {rxb(519), rxb(518), rxb(517), rxb(516)});

    // R11/R12/R1: free-running raw read, then soft reset
    clear_rx();
    base = done_seen;
    go(2'd0, 2'd0, 1'b0, 4'd15, 1'b0, 1'b1);
    for (int i = 0; i < 600; i++) begin
      get_word(v);
      if (i == 0 || i == 527 || i == 599) chk("R11 stream byte", v, {24'h0, rxb(i)});
    end
    chk("R11 still busy", {31'h0, busy}, 1);
    chk("R11 sect_cnt", {28'h0, sect_cnt}, 1);
    fdm_write(5, 32'hDEADBEEF);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R1 soft busy", {31'h0, busy}, 0);
    chk("R1 soft sect_cnt", {28'h0, sect_cnt}, 0);
    chk("R1 soft pio_ready", {31'h0, pio_ready}, 0);
    chk("R1 soft rx_ready", {31'h0, fl_rx_ready}, 0);
    chk("R11 no done", 32'(done_seen - base), 0);
    fdm_read(5, v);
    chk("R12 busy write ignored", v, fdm_val(5));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule